// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This block rewrites CPU-side request addresses for a host-to-serial-bus bridge. It holds a small set of translation regions. Each region has a 64-bit window base, a 32-bit inclusive limit, a 64-bit target address, a transaction type code and an enable. An address that falls inside an enabled region's window leaves the block as the region's target plus the offset into the window, tagged with that region's type code and index. An address that falls inside no region leaves unchanged, with a miss flag set.

Software programs the regions indirectly over a plain 32-bit register port. First it writes a selector register that chooses a direction and a region index. Every later access to the per-region registers then reaches the region that selector names. Only the outbound direction is built. While the selector points inbound, or at an index the block does not have, the per-region registers are neither written nor readable. The request path returns its result one clock after the request.

Top module: `atu_outbound`

## Requirements
- R1: After reset every register reads zero, every region is disabled, and a request comes back as a miss with its address unchanged.
- R2: The selector register at offset 0x900 stores the direction in bit 31 (1 inbound, 0 outbound) and the region index in bits 3:0, and reads back as written with all other bits zero.
- R3: Writes to the per-region offsets change the region named by the selector only when bit 31 is 0 and the index is below the region count. Otherwise the writes are dropped and those offsets read zero.
- R4: The per-region registers read back as written at these offsets: window base low 0x90C, window base high 0x910, limit 0x914, target low 0x918, target high 0x91C, type code in bits 2:0 of 0x904, and enable in bit 31 of 0x908. Other bits read zero.
- R5: A request hits a region when the region is enabled, address bits 63:32 equal the window base high word, and address bits 31:0 lie between the window base low word and the limit, both ends included.
- R6: On a hit, the output address is the 64-bit target plus (request address minus 64-bit window base), with carries passing between the two halves.
- R7: On a hit, the output type is the region's stored code (0 memory, 2 I/O, 4 type-0 config, 5 type-1 config) and the output region field is the region's index.
- R8: When more than one region hits, the lowest-numbered region supplies the result.
- R9: When no region hits, the output address equals the request address, the miss flag is 1, and the type and region fields are 0.
- R10: The output valid strobe is asserted exactly one cycle after each request-valid cycle and is low otherwise. The output address, type, region and miss fields change only after a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | input | 1 | Request present |
| req_addr | input | 64 | CPU-side request address |
| rsp_valid | output | 1 | Result present, one cycle after the request |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_type | output | 3 | Transaction type code of the hit region |
| rsp_region | output | $clog2(NUM_REGIONS) | Index of the hit region |
| rsp_miss | output | 1 | No region hit |

## Verification
The bench builds the block with its defaults: two regions and a 4-bit region index in the selector. With two regions the bench can overlap their windows, which exercises the lowest-index priority and the fall-back to region 1 when region 0 is disabled. The 4-bit index lets the bench select index 2, so writes aimed at a region that does not exist can be tested beside writes made while the inbound direction is selected. Region 1's target sits just below a 4 GiB boundary, which forces the translation add to carry into the upper word.

// File: rtl/atu_pkg.sv
`timescale 1ns/1ps
package atu_pkg;

  localparam int REG_AW  = 12;
  localparam int ADDR_W  = 64;
  localparam int WORD_W  = 32;
  localparam int KIND_W  = 3;

  localparam logic [REG_AW-1:0] OFS_SELECT = 12'h900;
  localparam logic [REG_AW-1:0] OFS_KIND   = 12'h904;
  localparam logic [REG_AW-1:0] OFS_ENABLE = 12'h908;
  localparam logic [REG_AW-1:0] OFS_BASE_L = 12'h90C;
  localparam logic [REG_AW-1:0] OFS_BASE_H = 12'h910;
  localparam logic [REG_AW-1:0] OFS_LIMIT  = 12'h914;
  localparam logic [REG_AW-1:0] OFS_TGT_L  = 12'h918;
  localparam logic [REG_AW-1:0] OFS_TGT_H  = 12'h91C;

  localparam logic [KIND_W-1:0] KIND_MEM  = 3'd0;
  localparam logic [KIND_W-1:0] KIND_IO   = 3'd2;
  localparam logic [KIND_W-1:0] KIND_CFG0 = 3'd4;
  localparam logic [KIND_W-1:0] KIND_CFG1 = 3'd5;

  typedef struct packed {
    logic              en;
    logic [KIND_W-1:0] kind;
    logic [WORD_W-1:0] base_l;
    logic [WORD_W-1:0] base_h;
    logic [WORD_W-1:0] limit;
    logic [WORD_W-1:0] tgt_l;
    logic [WORD_W-1:0] tgt_h;
  } window_cfg_t;

endpackage

// File: rtl/atu_regfile.sv
`timescale 1ns/1ps
module atu_regfile
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int SEL_W       = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [REG_AW-1:0]                   addr,
  input  logic [WORD_W-1:0]                   wdata,
  output logic [WORD_W-1:0]                   rdata,
  output window_cfg_t [NUM_REGIONS-1:0]       cfg
);

  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam logic [SEL_W-1:0] NREG_V = SEL_W'(NUM_REGIONS);

  logic                            dir_q, dir_d;
  logic [SEL_W-1:0]                idx_q, idx_d;
  window_cfg_t [NUM_REGIONS-1:0]   cfg_q, cfg_d;
  logic                            sel_ok;
  logic [IDX_W-1:0]                sel;

  assign sel_ok = !dir_q && (idx_q < NREG_V);
  assign sel    = idx_q[IDX_W-1:0];
  assign cfg    = cfg_q;

  // next state
  always_comb begin
    dir_d = dir_q;
    idx_d = idx_q;
    cfg_d = cfg_q;
    if (wr_en) begin
      if (addr == OFS_SELECT) begin
        dir_d = wdata[WORD_W-1];
        idx_d = wdata[SEL_W-1:0];
      end else if (sel_ok) begin
        case (addr)
          OFS_KIND:   cfg_d[sel].kind   = wdata[KIND_W-1:0];
          OFS_ENABLE: cfg_d[sel].en     = wdata[WORD_W-1];
          OFS_BASE_L: cfg_d[sel].base_l = wdata;
          OFS_BASE_H: cfg_d[sel].base_h = wdata;
          OFS_LIMIT:  cfg_d[sel].limit  = wdata;
          OFS_TGT_L:  cfg_d[sel].tgt_l  = wdata;
          OFS_TGT_H:  cfg_d[sel].tgt_h  = wdata;
          default: ;
        endcase
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      idx_q <= '0;
      cfg_q <= '0;
    end else if (wr_en) begin
      dir_q <= dir_d;
      idx_q <= idx_d;
      cfg_q <= cfg_d;
    end
  end

  // readback
  always_comb begin
    rdata = '0;
    if (addr == OFS_SELECT) begin
      rdata[WORD_W-1]  = dir_q;
      rdata[SEL_W-1:0] = idx_q;
    end else if (sel_ok) begin
      case (addr)
        OFS_KIND:   rdata[KIND_W-1:0] = cfg_q[sel].kind;
        OFS_ENABLE: rdata[WORD_W-1]   = cfg_q[sel].en;
        OFS_BASE_L: rdata = cfg_q[sel].base_l;
        OFS_BASE_H: rdata = cfg_q[sel].base_h;
        OFS_LIMIT:  rdata = cfg_q[sel].limit;
        OFS_TGT_L:  rdata = cfg_q[sel].tgt_l;
        OFS_TGT_H:  rdata = cfg_q[sel].tgt_h;
        default:    rdata = '0;
      endcase
    end
  end

  AST_DROPPED_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_ok && addr != OFS_SELECT) |=> $stable(cfg_q)); // R3

  AST_SELECT_TAKES_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_SELECT) |=> (dir_q == $past(wdata[WORD_W-1]))); // R2

endmodule

// File: rtl/atu_window.sv
`timescale 1ns/1ps
module atu_window
  import atu_pkg::*;
(
  input  window_cfg_t        cfg,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit,
  output logic [ADDR_W-1:0]  xaddr
);

  logic [ADDR_W-1:0] base64;
  logic [ADDR_W-1:0] tgt64;
  logic              in_low;

  assign base64 = {cfg.base_h, cfg.base_l};
  assign tgt64  = {cfg.tgt_h, cfg.tgt_l};
  assign in_low = (addr[WORD_W-1:0] >= cfg.base_l) && (addr[WORD_W-1:0] <= cfg.limit);
  assign hit    = cfg.en && (addr[ADDR_W-1:WORD_W] == cfg.base_h) && in_low;
  assign xaddr  = tgt64 + (addr - base64);

endmodule

// File: rtl/atu_pick.sv
`timescale 1ns/1ps
module atu_pick
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  input  logic [ADDR_W-1:0]                     req_addr,
  input  logic [NUM_REGIONS-1:0]                hit,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]    xaddr,
  input  logic [NUM_REGIONS-1:0][KIND_W-1:0]    kind,
  output logic                                  out_valid,
  output logic [ADDR_W-1:0]                     out_addr,
  output logic [KIND_W-1:0]                     out_kind,
  output logic [((NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1)-1:0] out_region,
  output logic                                  out_miss
);

  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  logic [ADDR_W-1:0] addr_d;
  logic [KIND_W-1:0] kind_d;
  logic [IDX_W-1:0]  region_d;
  logic              miss_d;

  // lowest index wins: scan from the top down
  always_comb begin
    addr_d   = req_addr;
    kind_d   = '0;
    region_d = '0;
    miss_d   = 1'b1;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        addr_d   = xaddr[i];
        kind_d   = kind[i];
        region_d = IDX_W'(i);
        miss_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr   <= '0;
      out_kind   <= '0;
      out_region <= '0;
      out_miss   <= 1'b0;
    end else if (req_valid) begin
      out_addr   <= addr_d;
      out_kind   <= kind_d;
      out_region <= region_d;
      out_miss   <= miss_d;
    end
  end

  AST_LOW_INDEX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit[0]) |=> (out_region == '0 && !out_miss)); // R8

  AST_MISS_PASSES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit == '0) |=> (out_miss && out_addr == $past(req_addr))); // R9

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R10

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid); // R10

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(out_addr)); // R10

endmodule

// File: rtl/atu_outbound.sv
`timescale 1ns/1ps
module atu_outbound
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int SEL_W       = 4
) (
  input  logic                 clk,
  input  logic                 arst_n,
  input  logic                 reg_wr,
  input  logic [11:0]          reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 req_valid,
  input  logic [63:0]          req_addr,
  output logic                 rsp_valid,
  output logic [63:0]          rsp_addr,
  output logic [2:0]           rsp_type,
  output logic [((NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1)-1:0] rsp_region,
  output logic                 rsp_miss
);

  logic [1:0]                              rst_sync_q;
  logic                                    rst_n;
  window_cfg_t [NUM_REGIONS-1:0]           cfg;
  logic [NUM_REGIONS-1:0]                  hit;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0]      xaddr;
  logic [NUM_REGIONS-1:0][KIND_W-1:0]      kind;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  atu_regfile #(
    .NUM_REGIONS (NUM_REGIONS),
    .SEL_W       (SEL_W)
  ) i_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
    atu_window i_win (
      .cfg   (cfg[g]),
      .addr  (req_addr),
      .hit   (hit[g]),
      .xaddr (xaddr[g])
    );
    assign kind[g] = cfg[g].kind;
  end

  atu_pick #(
    .NUM_REGIONS (NUM_REGIONS)
  ) i_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .hit        (hit),
    .xaddr      (xaddr),
    .kind       (kind),
    .out_valid  (rsp_valid),
    .out_addr   (rsp_addr),
    .out_kind   (rsp_type),
    .out_region (rsp_region),
    .out_miss   (rsp_miss)
  );

  AST_DISABLED_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cfg[0].en && !cfg[NUM_REGIONS-1].en) |=> rsp_miss); // R5

endmodule

// File: tb/test_atu_outbound.sv
`timescale 1ns/1ps
module test_atu_outbound;

  logic        clk;
  logic        arst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic [63:0] req_addr;
  logic        rsp_valid;
  logic [63:0] rsp_addr;
  logic [2:0]  rsp_type;
  logic [0:0]  rsp_region;
  logic        rsp_miss;

  int errs   = 0;
  int checks = 0;
  bit done   = 0;

  atu_outbound i_atu_outbound (
    .clk        (clk),
    .arst_n     (arst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_addr   (rsp_addr),
    .rsp_type   (rsp_type),
    .rsp_region (rsp_region),
    .rsp_miss   (rsp_miss)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // request vectors: address, expected address, miss, region, type
  localparam int NV = 9;
  localparam logic [63:0] V_ADDR [NV] = '{
    64'h0000_0001_1000_0000, 64'h0000_0001_1000_FFFF, 64'h0000_0001_1001_0000,
    64'h0000_0001_1000_8000, 64'h0000_0001_1001_7FFF, 64'h0000_0001_1001_8000,
    64'h0000_0001_0FFF_FFFF, 64'h0000_0002_1000_0000, 64'h0000_0001_1000_8001};
  localparam logic [63:0] V_EXP [NV] = '{
    64'h0000_0000_0311_0000, 64'h0000_0000_0311_FFFF, 64'h0000_0003_0000_7000,
    64'h0000_0000_0311_8000, 64'h0000_0003_0000_EFFF, 64'h0000_0001_1001_8000,
    64'h0000_0001_0FFF_FFFF, 64'h0000_0002_1000_0000, 64'h0000_0000_0311_8001};
  localparam logic V_MISS [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 0};
  localparam logic V_REG  [NV] = '{0, 0, 1, 0, 1, 0, 0, 0, 0};
  localparam logic [2:0] V_TYPE [NV] = '{4, 4, 0, 4, 0, 0, 0, 0, 4};

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic send(input logic [63:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input logic [63:0] a, input bit miss, input bit regn,
                            input logic [2:0] typ, input string req);
    check(rsp_valid == 1'b1, {req, " valid"}, 64'(rsp_valid), 64'd1);
    check(rsp_addr == a, {req, " addr"}, rsp_addr, a);
    check(rsp_miss == miss, {req, " miss"}, 64'(rsp_miss), 64'(miss));
    check(rsp_region == regn, {req, " region"}, 64'(rsp_region), 64'(regn));
    check(rsp_type == typ, {req, " type"}, 64'(rsp_type), 64'(typ));
  endtask

  task automatic prog(input logic [3:0] idx, input logic [31:0] bl, input logic [31:0] bh,
                      input logic [31:0] lim, input logic [31:0] tl, input logic [31:0] th,
                      input logic [2:0] typ, input bit en);
    wr(12'h900, {28'd0, idx});
    wr(12'h90C, bl);
    wr(12'h910, bh);
    wr(12'h914, lim);
    wr(12'h918, tl);
    wr(12'h91C, th);
    wr(12'h904, {29'd0, typ});
    wr(12'h908, {en, 31'd0});
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    req_valid = 1'b0; req_addr = '0;
    repeat (4) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    rd(12'h900, 32'h0, "R1 select reg after reset");
    rd(12'h90C, 32'h0, "R1 base low after reset");
    rd(12'h908, 32'h0, "R1 enable after reset");
    send(64'h0000_0001_1000_0000);
    expect_rsp(64'h0000_0001_1000_0000, 1'b1, 1'b0, 3'd0, "R1 request after reset");

    // program: region 0 cfg0 target bus 3 dev 2 func 1, region 1 memory
    prog(4'd0, 32'h1000_0000, 32'h1, 32'h1000_FFFF, 32'h0311_0000, 32'h0, 3'd4, 1'b1);
    prog(4'd1, 32'h1000_8000, 32'h1, 32'h1001_7FFF, 32'hFFFF_F000, 32'h2, 3'd0, 1'b1);

    // R2 / R4 readback
    rd(12'h900, 32'h0000_0001, "R2 select reads index 1");
    rd(12'h90C, 32'h1000_8000, "R4 base low");
    rd(12'h910, 32'h0000_0001, "R4 base high");
    rd(12'h914, 32'h1001_7FFF, "R4 limit");
    rd(12'h918, 32'hFFFF_F000, "R4 target low");
    rd(12'h91C, 32'h0000_0002, "R4 target high");
    rd(12'h904, 32'h0000_0000, "R4 type");
    rd(12'h908, 32'h8000_0000, "R4 enable");
    wr(12'h900, 32'h0);
    rd(12'h904, 32'h0000_0004, "R4 type region0");
    rd(12'h918, 32'h0311_0000, "R4 target low region0");

    // table walk: R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      send(V_ADDR[v]);
      expect_rsp(V_EXP[v], V_MISS[v], V_REG[v], V_TYPE[v], $sformatf("R5/R6/R7/R8/R9 vec%0d", v));
    end

    // R10: no request, valid drops and fields hold
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 valid low when idle", 64'(rsp_valid), 64'd0);
    check(rsp_addr == V_EXP[NV-1], "R10 addr holds when idle", rsp_addr, V_EXP[NV-1]);

    // R3: inbound selection drops writes
    wr(12'h900, 32'h8000_0000);
    rd(12'h900, 32'h8000_0000, "R2 select inbound readback");
    wr(12'h90C, 32'hDEAD_0000);
    wr(12'h908, 32'h0);
    rd(12'h90C, 32'h0, "R3 region reg reads zero when inbound");
    wr(12'h900, 32'h0);
    rd(12'h90C, 32'h1000_0000, "R3 inbound write dropped");
    rd(12'h908, 32'h8000_0000, "R3 inbound enable write dropped");

    // R3: index beyond region count drops writes
    wr(12'h900, 32'h2);
    wr(12'h904, 32'h5);
    wr(12'h90C, 32'h0);
    rd(12'h904, 32'h0, "R3 region reg reads zero for index 2");
    wr(12'h900, 32'h0);
    rd(12'h904, 32'h4, "R3 index 2 type write dropped");
    send(64'h0000_0001_1000_0000);
    expect_rsp(64'h0000_0000_0311_0000, 1'b0, 1'b0, 3'd4, "R3 region0 still translates");

    // R8: disable region 0, overlap now goes to region 1
    wr(12'h908, 32'h0);
    send(64'h0000_0001_1000_8000);
    expect_rsp(64'h0000_0002_FFFF_F000, 1'b0, 1'b1, 3'd0, "R8 region1 when region0 off");
    send(64'h0000_0001_1000_0000);
    expect_rsp(64'h0000_0001_1000_0000, 1'b1, 1'b0, 3'd0, "R5 disabled region misses");

    // R7: other type codes
    wr(12'h900, 32'h1);
    wr(12'h904, 32'h2);
    send(64'h0000_0001_1001_0000);
    expect_rsp(64'h0000_0003_0000_7000, 1'b0, 1'b1, 3'd2, "R7 I/O type");
    wr(12'h904, 32'h5);
    send(64'h0000_0001_1001_0000);
    expect_rsp(64'h0000_0003_0000_7000, 1'b0, 1'b1, 3'd5, "R7 type-1 config");

    // R10: back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_addr = 64'h0000_0001_1000_8000;
    @(negedge clk);
    check(rsp_valid == 1'b1, "R10 first of pair valid", 64'(rsp_valid), 64'd1);
    check(rsp_addr == 64'h0000_0002_FFFF_F000, "R10 first of pair addr", rsp_addr, 64'h0000_0002_FFFF_F000);
    req_addr = 64'h0000_0003_0000_0000;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1 && rsp_miss == 1'b1, "R10 second of pair miss", 64'(rsp_miss), 64'd1);
    check(rsp_addr == 64'h0000_0003_0000_0000, "R10 second of pair addr", rsp_addr, 64'h0000_0003_0000_0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule